// File: doc/BRIEF.md
# Fieldbus Frame Serializer

This block sends one complete fieldbus frame each time a processor asks for one. A rising edge on the start input takes a snapshot of four inputs: a control byte, a bank of 32-bit payload words, a payload byte count and a bit-rate code. The processor may then rewrite its registers freely while the frame goes out. The block produces a Manchester-encoded serial stream, a transmit-enable output that brackets the frame, and a bit clock. At the end it raises a one-cycle completion pulse.

The block knows nothing about what the payload means. It builds the framing around the bytes it is given: a head (an alternating preamble followed by a start delimiter), the control byte, the payload bytes, a 16-bit check sequence and an end delimiter. The processor decides when frames go out and what is in them. Bit timing comes from a 100 MHz system clock divided down to one of four fixed rates.

Top module: `fbtx_serializer`

## Requirements
- R1: A frame starts only on a 0-to-1 change of `start_i` seen while idle. `start_i` held high after a frame ends starts no second frame.
- R2: At the start edge, `ctrl_i`, `words_i`, `count_i` and `rate_i` are captured. Changes on these inputs during the frame do not alter the frame.
- R3: The frame is sent as a sequence of symbols, each made of two half-bit periods. A data 1 is sent as high then low, and a data 0 as low then high. V+ is high for both halves and V- is low for both halves. The symbols are sent in this order:
  - preamble: 1,0,1,0,1,0,1,0
  - start delimiter: 1,V+,V-,1,0,V-,V+,0
  - the control byte
  - the payload bytes
  - the 16 check bits
  - end delimiter: 1,V+,V-,V+,V-,1,0,1
- R4: `count_i` is the number of payload bytes that follow the control byte. Payload byte k is bits [8*(k mod 4)+7 : 8*(k mod 4)] of word k/4, where word w is `words_i[32*w+31 : 32*w]`. Every byte is sent most significant bit first.
- R5: The check sequence is a 16-bit CRC with generator 0x1DCF and seed 0x0000, processed MSB first over the control byte and the payload bytes. It is sent inverted, bit 15 first.
- R6: The half-bit period is H clock cycles, where H is 1600, 50, 20 or 10 for `rate_i` 0, 1, 2 or 3 (31.25 kbit/s, 1, 2.5 and 5 Mbit/s at 100 MHz).
  - `txen_o` is high for exactly (number of half-bits) × H cycles, starting with the cycle after the clock edge that samples the start edge.
  - `txck_o` is high in the first half of each bit and low in the second.
  - `txd_o` and `txck_o` are low whenever `txen_o` is low.
- R7: `done_o` is high for exactly one cycle: the first cycle in which `txen_o` is low again after a frame.
- R8: A start edge that arrives while a frame is in progress is ignored. The frame keeps its length and content, and no frame follows it.
- R9: A `count_i` greater than 268 (67 words × 4 bytes) is treated as 268.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 100 MHz system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transmit request; its rising edge starts a frame |
| rate_i | input | 2 | Bit-rate code, captured at start |
| ctrl_i | input | 8 | Control byte, captured at start |
| count_i | input | 9 | Payload byte count, captured at start |
| words_i | input | 2144 | 67 payload words of 32 bits, captured at start |
| txd_o | output | 1 | Manchester serial data |
| txen_o | output | 1 | Transmit enable, high for the whole frame |
| txck_o | output | 1 | Bit clock, high in the first half of each bit |
| done_o | output | 1 | One-cycle pulse at frame completion |

## Verification
The bench records every cycle of each frame and compares the record half-bit by half-bit against a stream built from the requirements. A wrong byte lane, a wrong bit order, a bad CRC or a swapped delimiter therefore shows up as a half-bit mismatch, and an off-by-one in the counters shows up as a wrong frame length. Four cases are aimed at specific failures:
- All inputs are inverted and the rate code is changed mid-frame. A block without a full snapshot would emit altered bytes or a wrong frame length.
- `start_i` is pulsed again mid-frame. A block that restarts on it, or queues it, would produce a longer frame or a second one.
- `start_i` is held high after the frame ends. A block that triggers on level would send another frame.
- An oversized byte count is given. A block without the clamp to 268 would run past the payload bank.

// File: rtl/fbtx_pkg.sv
package fbtx_pkg;

    // Half-bit patterns, first half in bit 15.
    localparam logic [15:0] PREAMBLE_HALVES    = 16'h9999;
    localparam logic [15:0] START_DELIM_HALVES = 16'hB24D;
    localparam logic [15:0] END_DELIM_HALVES   = 16'hB326;

    localparam logic [15:0] CRC_POLY = 16'h1DCF;
    localparam logic [15:0] CRC_SEED = 16'h0000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HEAD,
        PH_BODY,
        PH_CHECK,
        PH_TAIL
    } phase_e;

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ b[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    // Clock cycles per half bit for each rate code.
    function automatic int unsigned half_cycles(input int unsigned clk_hz, input logic [1:0] sel);
        case (sel)
            2'd0:    return clk_hz / 62_500;
            2'd1:    return clk_hz / 2_000_000;
            2'd2:    return clk_hz / 5_000_000;
            default: return clk_hz / 10_000_000;
        endcase
    endfunction

endpackage

// File: rtl/fbtx_bit_timer.sv
module fbtx_bit_timer #(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    output logic       half_end_o,
    output logic       bclk_o
);
    localparam int unsigned SLOWEST = fbtx_pkg::half_cycles(CLK_HZ, 2'd0);
    localparam int unsigned CW      = $clog2(SLOWEST + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          second;
    } tmr_t;

    logic [CW-1:0] lim [4];
    tmr_t tmr_d, tmr_q;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lim[g] = CW'(fbtx_pkg::half_cycles(CLK_HZ, 2'(g)) - 1);
    end

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d.cnt    = '0;
            tmr_d.second = 1'b0;
        end else if (tmr_q.cnt == lim[rate_i]) begin
            tmr_d.cnt    = '0;
            tmr_d.second = ~tmr_q.second;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign half_end_o = run_i && (tmr_q.cnt == lim[rate_i]);
    assign bclk_o     = run_i && !tmr_q.second;

endmodule

// File: rtl/fbtx_frame_store.sv
module fbtx_frame_store #(
    parameter int unsigned NWORDS = 67,
    parameter int unsigned MAXB   = NWORDS * 4,
    parameter int unsigned CNTW   = $clog2(MAXB + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  load_i,
    input  logic [7:0]            ctrl_i,
    input  logic [CNTW-1:0]       count_i,
    input  logic [1:0]            rate_i,
    input  logic [NWORDS*32-1:0]  words_i,
    input  logic [CNTW-1:0]       sel_i,
    output logic [7:0]            byte_o,
    output logic [CNTW-1:0]       count_o,
    output logic [1:0]            rate_o
);
    typedef struct packed {
        logic [7:0]      ctrl;
        logic [CNTW-1:0] count;
        logic [1:0]      rate;
    } hdr_t;

    hdr_t        hdr_d, hdr_q;
    logic [31:0] word_q [NWORDS];

    always_comb begin
        hdr_d = hdr_q;
        if (load_i) begin
            hdr_d.ctrl  = ctrl_i;
            hdr_d.rate  = rate_i;
            hdr_d.count = (count_i > CNTW'(MAXB)) ? CNTW'(MAXB) : count_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hdr_q <= '0;
        else         hdr_q <= hdr_d;
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [31:0] w_d, w_q;
        always_comb w_d = load_i ? words_i[g*32 +: 32] : w_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) w_q <= '0;
            else         w_q <= w_d;
        end
        assign word_q[g] = w_q;
    end

    logic [CNTW-1:0] pidx;
    int unsigned     wsel;
    logic [31:0]     picked;

    always_comb begin
        pidx   = sel_i - 1'b1;
        wsel   = 32'(pidx >> 2);
        picked = '0;
        for (int unsigned w = 0; w < NWORDS; w++) begin
            if (wsel == w) picked = word_q[w];
        end
        byte_o = (sel_i == '0) ? hdr_q.ctrl : picked[{pidx[1:0], 3'b000} +: 8];
    end

    assign count_o = hdr_q.count;
    assign rate_o  = hdr_q.rate;

endmodule

// File: rtl/fbtx_sequencer.sv
module fbtx_sequencer #(
    parameter int unsigned CNTW = 9
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            half_end_i,
    input  logic [7:0]      byte_i,
    input  logic [CNTW-1:0] count_i,
    output logic            load_o,
    output logic            busy_o,
    output logic [CNTW-1:0] sel_o,
    output logic            txd_o,
    output logic            done_o
);
    import fbtx_pkg::*;

    typedef struct packed {
        phase_e          phase;
        logic [4:0]      hcnt;
        logic [CNTW-1:0] bidx;
        logic [15:0]     crc;
        logic            start_prev;
        logic            done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic start_edge;

    always_comb begin
        seq_d            = seq_q;
        seq_d.start_prev = start_i;
        seq_d.done       = 1'b0;
        load_o           = 1'b0;
        start_edge       = start_i && !seq_q.start_prev;

        case (seq_q.phase)
            PH_IDLE: begin
                if (start_edge) begin
                    load_o      = 1'b1;
                    seq_d.phase = PH_HEAD;
                    seq_d.hcnt  = '0;
                    seq_d.bidx  = '0;
                    seq_d.crc   = CRC_SEED;
                end
            end
            PH_HEAD: begin
                if (half_end_i) begin
                    if (seq_q.hcnt == 5'd31) begin
                        seq_d.phase = PH_BODY;
                        seq_d.hcnt  = '0;
                    end else begin
                        seq_d.hcnt = seq_q.hcnt + 1'b1;
                    end
                end
            end
            PH_BODY: begin
                if (half_end_i) begin
                    if (seq_q.hcnt == 5'd15) begin
                        seq_d.crc  = crc_byte(seq_q.crc, byte_i);
                        seq_d.hcnt = '0;
                        if (seq_q.bidx == count_i) seq_d.phase = PH_CHECK;
                        else                       seq_d.bidx  = seq_q.bidx + 1'b1;
                    end else begin
                        seq_d.hcnt = seq_q.hcnt + 1'b1;
                    end
                end
            end
            PH_CHECK: begin
                if (half_end_i) begin
                    if (seq_q.hcnt == 5'd31) begin
                        seq_d.phase = PH_TAIL;
                        seq_d.hcnt  = '0;
                    end else begin
                        seq_d.hcnt = seq_q.hcnt + 1'b1;
                    end
                end
            end
            PH_TAIL: begin
                if (half_end_i) begin
                    if (seq_q.hcnt == 5'd15) begin
                        seq_d.phase = PH_IDLE;
                        seq_d.hcnt  = '0;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.hcnt = seq_q.hcnt + 1'b1;
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Symbol half currently on the line.
    always_comb begin
        case (seq_q.phase)
            PH_HEAD:  txd_o = seq_q.hcnt[4] ? START_DELIM_HALVES[~seq_q.hcnt[3:0]]
                                            : PREAMBLE_HALVES[~seq_q.hcnt[3:0]];
            PH_BODY:  txd_o = byte_i[~seq_q.hcnt[3:1]] ^ seq_q.hcnt[0];
            PH_CHECK: txd_o = ~seq_q.crc[~seq_q.hcnt[4:1]] ^ seq_q.hcnt[0];
            PH_TAIL:  txd_o = END_DELIM_HALVES[~seq_q.hcnt[3:0]];
            default:  txd_o = 1'b0;
        endcase
    end

    assign busy_o = (seq_q.phase != PH_IDLE);
    assign sel_o  = seq_q.bidx;
    assign done_o = seq_q.done;

endmodule

// File: rtl/fbtx_serializer.sv
module fbtx_serializer #(
    parameter  int unsigned NWORDS = 67,
    parameter  int unsigned CLK_HZ = 100_000_000,
    localparam int unsigned MAXB   = NWORDS * 4,
    localparam int unsigned CNTW   = $clog2(MAXB + 1)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [1:0]           rate_i,
    input  logic [7:0]           ctrl_i,
    input  logic [CNTW-1:0]      count_i,
    input  logic [NWORDS*32-1:0] words_i,
    output logic                 txd_o,
    output logic                 txen_o,
    output logic                 txck_o,
    output logic                 done_o
);
    logic            load;
    logic            busy;
    logic            half_end;
    logic [CNTW-1:0] sel;
    logic [7:0]      cur_byte;
    logic [CNTW-1:0] snap_count;
    logic [1:0]      snap_rate;

    fbtx_frame_store #(.NWORDS(NWORDS), .MAXB(MAXB), .CNTW(CNTW)) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .ctrl_i  (ctrl_i),
        .count_i (count_i),
        .rate_i  (rate_i),
        .words_i (words_i),
        .sel_i   (sel),
        .byte_o  (cur_byte),
        .count_o (snap_count),
        .rate_o  (snap_rate)
    );

    fbtx_bit_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (busy),
        .rate_i     (snap_rate),
        .half_end_o (half_end),
        .bclk_o     (txck_o)
    );

    fbtx_sequencer #(.CNTW(CNTW)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .half_end_i (half_end),
        .byte_i     (cur_byte),
        .count_i    (snap_count),
        .load_o     (load),
        .busy_o     (busy),
        .sel_o      (sel),
        .txd_o      (txd_o),
        .done_o     (done_o)
    );

    assign txen_o = busy;

endmodule

// File: rtl/fbtx_serializer_chk.sv
module fbtx_serializer_chk #(
    parameter int unsigned MAXB = 268,
    parameter int unsigned CNTW = 9
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            start_i,
    input logic            txd_o,
    input logic            txen_o,
    input logic            txck_o,
    input logic            done_o,
    input logic [CNTW-1:0] snap_count
);
    // R6: line quiet outside a frame
    a_r6_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !txen_o |-> (!txd_o && !txck_o));

    // R7: completion pulse is a single cycle
    a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7: every frame end is flagged
    a_r7_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(txen_o) |-> done_o);

    // R7: flag only right after a frame
    a_r7_done_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!txen_o && $past(txen_o)));

    // R1: a frame begins only from a start request
    a_r1_rise_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(txen_o) |-> $past(start_i));

    // R9: stored byte count never beyond bank size
    a_r9_count_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txen_o |-> (snap_count <= CNTW'(MAXB)));

endmodule

bind fbtx_serializer fbtx_serializer_chk #(.MAXB(MAXB), .CNTW(CNTW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .txd_o      (txd_o),
    .txen_o     (txen_o),
    .txck_o     (txck_o),
    .done_o     (done_o),
    .snap_count (snap_count)
);

// File: tb/fbtx_serializer_test.sv
module fbtx_serializer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NW         = 67;
    localparam int MAXB       = NW * 4;
    localparam int CNTW       = 9;

    localparam int M_NORMAL = 0;
    localparam int M_SNAP   = 1;
    localparam int M_RETRIG = 2;
    localparam int M_HOLD   = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [1:0]        rate;
    logic [7:0]        ctrl;
    logic [CNTW-1:0]   count;
    logic [NW*32-1:0]  pay;
    logic              txd, txen, txck, done;

    fbtx_serializer uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .rate_i  (rate),
        .ctrl_i  (ctrl),
        .count_i (count),
        .words_i (pay),
        .txd_o   (txd),
        .txen_o  (txen),
        .txck_o  (txck),
        .done_o  (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    bit cap_d [0:65535];
    bit cap_c [0:65535];
    int cap_len;
    bit exp_h [0:8191];
    int exp_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int half_of(input logic [1:0] r);
        case (r)
            2'd0:    return 1600;
            2'd1:    return 50;
            2'd2:    return 20;
            default: return 10;
        endcase
    endfunction

    // symbol codes: 0, 1, 2 = V+, 3 = V-
    task automatic push_sym(input int code);
        case (code)
            1:       begin exp_h[exp_n] = 1; exp_h[exp_n+1] = 0; end
            0:       begin exp_h[exp_n] = 0; exp_h[exp_n+1] = 1; end
            2:       begin exp_h[exp_n] = 1; exp_h[exp_n+1] = 1; end
            default: begin exp_h[exp_n] = 0; exp_h[exp_n+1] = 0; end
        endcase
        exp_n += 2;
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) push_sym(int'(b[i]));
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] != b[i]) r = (r << 1) ^ 16'h1DCF;
            else               r = r << 1;
        end
        return r;
    endfunction

    task automatic build_expected(input logic [7:0] c, input int n, input logic [NW*32-1:0] w);
        int sd [8] = '{1, 2, 3, 1, 0, 3, 2, 0};
        int ed [8] = '{1, 2, 3, 2, 3, 1, 0, 1};
        logic [15:0] crc = 16'h0000;
        logic [7:0]  b;
        exp_n = 0;
        for (int i = 0; i < 8; i++) push_sym((i % 2 == 0) ? 1 : 0);
        for (int i = 0; i < 8; i++) push_sym(sd[i]);
        push_byte(c);
        crc = ref_crc(crc, c);
        for (int k = 0; k < n; k++) begin
            b = w[(k / 4) * 32 + (k % 4) * 8 +: 8];
            push_byte(b);
            crc = ref_crc(crc, b);
        end
        crc = ~crc;
        for (int i = 15; i >= 0; i--) push_sym(int'(crc[i]));
        for (int i = 0; i < 8; i++) push_sym(ed[i]);
    endtask

    task automatic run_frame(input string req, input logic [7:0] c, input int cnt,
                             input logic [1:0] r, input int mode);
        int  n_eff;
        int  h;
        int  mism;
        int  ckbad;
        bit  started;
        logic [NW*32-1:0] saved;
        @(negedge clk);
        ctrl  = c;
        count = CNTW'(cnt);
        rate  = r;
        saved = pay;
        start = 1'b1;
        n_eff = (cnt > MAXB) ? MAXB : cnt;
        h     = half_of(r);
        build_expected(c, n_eff, saved);
        cap_len = 0;
        started = 0;
        for (int guard = 0; guard < 60000; guard++) begin
            @(negedge clk);
            if (txen) begin
                cap_d[cap_len] = txd;
                cap_c[cap_len] = txck;
                cap_len++;
                started = 1;
            end else if (started) begin
                break;
            end
            if (mode != M_HOLD && cap_len == 5) start = 1'b0;
            if (mode == M_SNAP && cap_len == 100) begin
                pay   = ~pay;
                ctrl  = ~ctrl;
                count = CNTW'(3);
                rate  = 2'd0;
            end
            if (mode == M_RETRIG && cap_len == 100) start = 1'b1;
            if (mode == M_RETRIG && cap_len == 120) start = 1'b0;
        end
        chk(done == 1'b1, req, "R7 done high as txen falls", done, 1);
        chk(cap_len == exp_n * h, req, "R6 frame length in cycles", cap_len, exp_n * h);
        mism  = 0;
        ckbad = 0;
        for (int k = 0; k < exp_n && (k + 1) * h <= cap_len; k++) begin
            if (cap_d[k*h] != exp_h[k] || cap_d[k*h + h/2] != exp_h[k] ||
                cap_d[k*h + h - 1] != exp_h[k]) begin
                if (mism == 0)
                    $display("  half %0d mismatch: actual %0d expected %0d", k,
                             cap_d[k*h + h/2], exp_h[k]);
                mism++;
            end
            if (cap_c[k*h + h/2] != ((k % 2) == 0)) ckbad++;
        end
        chk(mism == 0, req, "R3 half-bit stream mismatches", mism, 0);
        chk(ckbad == 0, req, "R6 bit clock phase errors", ckbad, 0);
        @(negedge clk);
        chk(done == 1'b0, req, "R7 done one cycle only", done, 0);
    endtask

    task automatic watch_quiet(input string req, input int cycles);
        int rises = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txen) rises++;
        end
        chk(rises == 0, req, "no further frame (txen cycles)", rises, 0);
    endtask

    task automatic t_reset();
        chk(txen == 0 && txd == 0 && txck == 0 && done == 0, "R6",
            "outputs after reset", {txen, txd, txck, done}, 0);
    endtask

    task automatic t_basic();
        for (int w = 0; w < NW; w++) pay[w*32 +: 32] = 32'hA1B2C3D4 ^ (w * 32'h01030507);
        run_frame("R4", 8'hA5, 6, 2'd3, M_NORMAL);
    endtask

    task automatic t_zero();
        run_frame("R5", 8'h3C, 0, 2'd2, M_NORMAL);
    endtask

    task automatic t_rate1();
        run_frame("R6", 8'h81, 2, 2'd1, M_NORMAL);
    endtask

    task automatic t_snap();
        for (int w = 0; w < NW; w++) pay[w*32 +: 32] = 32'h5A0F0000 + w * 32'h00011111;
        run_frame("R2", 8'h96, 9, 2'd3, M_SNAP);
    endtask

    task automatic t_retrig();
        run_frame("R8", 8'h0F, 10, 2'd3, M_RETRIG);
        watch_quiet("R8", 300);
    endtask

    task automatic t_hold();
        run_frame("R1", 8'hE7, 1, 2'd3, M_HOLD);
        watch_quiet("R1", 300);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_max();
        for (int w = 0; w < NW; w++) pay[w*32 +: 32] = {8'(w), 8'(w + 64), 8'(~w), 8'(w * 3)};
        run_frame("R9", 8'h42, 300, 2'd3, M_NORMAL);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        rate  = 2'd3;
        ctrl  = 8'h00;
        count = '0;
        pay   = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_zero();
        t_rate1();
        t_snap();
        t_retrig();
        t_hold();
        t_max();
        repeat (5) @(negedge clk);
        summary();
    end

endmodule